// File: doc/BRIEF.md
# Subclock Idle Mode Controller

This block decides which clocks keep running while a small microcontroller sits in its subclock idle mode. The CPU raises a one-cycle entry request. From the next cycle on, the controller gates off the clocks of the CPU, DMA, interrupt controller and the fixed-function peripherals. Each timer and serial port keeps its clock only if it counts from a source that survives idle: the ring oscillator, the subclock, or an external pin. The subclock and ring oscillators stay enabled at all times. The PLL keeps running in idle only while the main clock is still oscillating.

A non-maskable or maskable interrupt request ends idle. One cycle later every clock enable is back on, and a one-cycle wake pulse comes out together with a resume code that tells the CPU to branch to its handler or to continue with the next instruction. A request to stop the main clock is only granted while the PLL is configured off. Reset acts the same whether the block is idle or running.

Top module: `lp_idle_ctrl`

## Requirements
- R1: After reset, `idleOn`, `portHold`, `wakeValid` and `wakeBranch` are 0, and every peripheral clock enable is 1.
- R2: An `idleReq` sampled high while running sets `idleOn` at the next clock edge. While `idleOn` is 1, `clkEnCpu`, `clkEnDma`, `clkEnIntc` and `clkEnAux` are 0.
- R3: `subOscEn` and `ringOscEn` are 1 in every state.
- R4: `pllEn` follows `pllOnCfg` while running. While idle it is `pllOnCfg` AND `mainClkRun`, so the PLL is off in idle whenever the main clock is stopped.
- R5: `mainStopAck` is 1 only when `mainStopReq` is 1 and `pllOnCfg` is 0. A stop request made with the PLL configured on is rejected.
- R6: While idle, `clkEnTmr` is 1 only when `tmrClkSel` is 1 (ring oscillator divided by 8) or 2 (subclock). It is 0 for codes 0 and 3.
- R7: While idle, `clkEnWatch` equals `watchClkSub`, where 1 means the subclock. `clkEnWdt` is 1 only when `wdtClkSel` is 1 (ring oscillator) or 2 (subclock).
- R8: While idle, bit n of `clkEnCsi` equals bit n of `csiExtClk`. Bit 0 of `clkEnUart` equals `uart0ExtClk`, and all higher `clkEnUart` bits are 0.
- R9: `clkEnKey` is 1 in every state. `portHold` equals `idleOn`.
- R10: An `nmi` sampled high while idle ends idle with `wakeBranch`=1, whatever the value of `intEnable`.
- R11: An `irqReq` sampled high while idle, with `nmi` low, ends idle with `wakeBranch` equal to `intEnable`: 1 means branch to the handler, 0 means continue with the next instruction.
- R12: At the clock edge that samples the wake request, `idleOn` drops and all clock enables return to 1. `wakeValid` is high for exactly that one following cycle.
- R13: A reset asserted during idle returns every output to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (subclock domain) |
| rstN | input | 1 | Asynchronous active-low reset |
| idleReq | input | 1 | One-cycle idle entry request from CPU |
| nmi | input | 1 | Non-maskable interrupt request |
| irqReq | input | 1 | Any maskable interrupt request pending |
| intEnable | input | 1 | Global maskable interrupt enable |
| mainClkRun | input | 1 | Main oscillator is running |
| pllOnCfg | input | 1 | Software PLL enable setting |
| mainStopReq | input | 1 | Request to stop the main oscillator |
| tmrClkSel | input | 2 | Timer count clock: 0 main, 1 ring/8, 2 subclock, 3 main alt |
| watchClkSub | input | 1 | Watch timer counts from subclock |
| wdtClkSel | input | 2 | Watchdog clock: 0 main, 1 ring, 2 subclock, 3 main alt |
| csiExtClk | input | NUM_CSI | Per synchronous port: clocked from external pin |
| uart0ExtClk | input | 1 | Async port 0 uses external clock input |
| idleOn | output | 1 | Idle mode active |
| clkEnCpu | output | 1 | CPU clock enable |
| clkEnDma | output | 1 | DMA clock enable |
| clkEnIntc | output | 1 | Interrupt controller clock enable |
| clkEnAux | output | 1 | Interval timers, watch-independent converters, CRC, CAN, I2C |
| clkEnTmr | output | 1 | General-purpose timer clock enable |
| clkEnWatch | output | 1 | Watch timer clock enable |
| clkEnWdt | output | 1 | Watchdog clock enable |
| clkEnCsi | output | NUM_CSI | Synchronous serial port clock enables |
| clkEnUart | output | NUM_UART | Asynchronous serial port clock enables |
| clkEnKey | output | 1 | Key-interrupt logic clock enable |
| portHold | output | 1 | Hold port output states |
| subOscEn | output | 1 | Subclock oscillator enable |
| ringOscEn | output | 1 | Ring oscillator enable |
| pllEn | output | 1 | PLL enable |
| mainStopAck | output | 1 | Main oscillator stop granted |
| wakeValid | output | 1 | One-cycle wake pulse |
| wakeBranch | output | 1 | Resume code: 1 branch to handler, 0 next instruction |

## Verification
On every cycle, the assertions check the gating of the core clocks while idle, the dependence of the PLL on the main clock, the rejection of a stop request while the PLL is configured on, the resume code chosen for each kind of interrupt and enable state, the one-cycle restore and the single-cycle wake pulse. Only the bench scenarios cover the full table of clock selections: each timer, watchdog and serial code is driven while idle and while running. The scenarios also cover the oscillator and key enables, and a reset that arrives in the middle of idle.

// File: rtl/lp_idle_pkg.sv
package lp_idle_pkg;

  localparam int SEL_W = 2;

  // count-clock selector codes shared by timer and watchdog
  localparam logic [SEL_W-1:0] SEL_MAIN     = 2'd0;
  localparam logic [SEL_W-1:0] SEL_RING     = 2'd1;
  localparam logic [SEL_W-1:0] SEL_SUB      = 2'd2;
  localparam logic [SEL_W-1:0] SEL_MAIN_ALT = 2'd3;

  typedef enum logic {ST_RUN = 1'b0, ST_IDLE = 1'b1} idle_state_e;

  typedef struct packed {
    logic gateOff;    // idle state active
    logic wakeStb;    // wake event accepted this cycle
    logic branchStb;  // resume code to latch with the wake
  } idle_ctrl_t;

  function automatic logic selSurvivesIdle(input logic [SEL_W-1:0] sel);
    return (sel == SEL_RING) || (sel == SEL_SUB);
  endfunction

endpackage

// File: rtl/lp_idle_fsm.sv
module lp_idle_fsm
  import lp_idle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleReq,
  input  logic       nmi,
  input  logic       irqReq,
  input  logic       intEnable,
  output idle_ctrl_t ctrl
);

  idle_state_e state, stateNext;
  logic wakeEvt;
  logic branchSel;

  assign wakeEvt   = nmi | irqReq;
  // a non-maskable request always branches; a maskable one only when enabled
  assign branchSel = nmi | (irqReq & intEnable);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:  if (idleReq) stateNext = ST_IDLE;
      ST_IDLE: if (wakeEvt) stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl.gateOff   = (state == ST_IDLE);
    ctrl.wakeStb   = (state == ST_IDLE) && wakeEvt;
    ctrl.branchStb = branchSel;
  end

endmodule

// File: rtl/lp_idle_gates.sv
module lp_idle_gates
  import lp_idle_pkg::*;
#(
  parameter int NUM_CSI  = 5,
  parameter int NUM_UART = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  idle_ctrl_t           ctrl,
  input  logic                 mainClkRun,
  input  logic                 pllOnCfg,
  input  logic                 mainStopReq,
  input  logic [SEL_W-1:0]     tmrClkSel,
  input  logic                 watchClkSub,
  input  logic [SEL_W-1:0]     wdtClkSel,
  input  logic [NUM_CSI-1:0]   csiExtClk,
  input  logic                 uart0ExtClk,
  output logic                 clkEnCpu,
  output logic                 clkEnDma,
  output logic                 clkEnIntc,
  output logic                 clkEnAux,
  output logic                 clkEnTmr,
  output logic                 clkEnWatch,
  output logic                 clkEnWdt,
  output logic [NUM_CSI-1:0]   clkEnCsi,
  output logic [NUM_UART-1:0]  clkEnUart,
  output logic                 clkEnKey,
  output logic                 portHold,
  output logic                 subOscEn,
  output logic                 ringOscEn,
  output logic                 pllEn,
  output logic                 mainStopAck,
  output logic                 wakeValid,
  output logic                 wakeBranch
);

  logic running;
  assign running = ~ctrl.gateOff;

  // core clocks: no exception while idle
  assign clkEnCpu  = running;
  assign clkEnDma  = running;
  assign clkEnIntc = running;
  assign clkEnAux  = running;

  // selection-dependent clocks
  assign clkEnTmr   = running | selSurvivesIdle(tmrClkSel);
  assign clkEnWatch = running | watchClkSub;
  assign clkEnWdt   = running | selSurvivesIdle(wdtClkSel);

  for (genvar i = 0; i < NUM_CSI; i++) begin : g_csi
    assign clkEnCsi[i] = running | csiExtClk[i];
  end

  for (genvar j = 0; j < NUM_UART; j++) begin : g_uart
    if (j == 0) begin : g_ext
      assign clkEnUart[j] = running | uart0ExtClk;
    end else begin : g_int
      assign clkEnUart[j] = running;
    end
  end

  assign clkEnKey  = 1'b1;
  assign portHold  = ctrl.gateOff;
  assign subOscEn  = 1'b1;
  assign ringOscEn = 1'b1;

  assign pllEn       = pllOnCfg & (running | mainClkRun);
  assign mainStopAck = mainStopReq & ~pllOnCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeValid  <= 1'b0;
      wakeBranch <= 1'b0;
    end else begin
      wakeValid <= ctrl.wakeStb;
      if (ctrl.wakeStb) wakeBranch <= ctrl.branchStb;
    end
  end

endmodule

// File: rtl/lp_idle_ctrl.sv
module lp_idle_ctrl
  import lp_idle_pkg::*;
#(
  parameter int NUM_CSI  = 5,
  parameter int NUM_UART = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 idleReq,
  input  logic                 nmi,
  input  logic                 irqReq,
  input  logic                 intEnable,
  input  logic                 mainClkRun,
  input  logic                 pllOnCfg,
  input  logic                 mainStopReq,
  input  logic [1:0]           tmrClkSel,
  input  logic                 watchClkSub,
  input  logic [1:0]           wdtClkSel,
  input  logic [NUM_CSI-1:0]   csiExtClk,
  input  logic                 uart0ExtClk,
  output logic                 idleOn,
  output logic                 clkEnCpu,
  output logic                 clkEnDma,
  output logic                 clkEnIntc,
  output logic                 clkEnAux,
  output logic                 clkEnTmr,
  output logic                 clkEnWatch,
  output logic                 clkEnWdt,
  output logic [NUM_CSI-1:0]   clkEnCsi,
  output logic [NUM_UART-1:0]  clkEnUart,
  output logic                 clkEnKey,
  output logic                 portHold,
  output logic                 subOscEn,
  output logic                 ringOscEn,
  output logic                 pllEn,
  output logic                 mainStopAck,
  output logic                 wakeValid,
  output logic                 wakeBranch
);

  idle_ctrl_t ctrl;

  lp_idle_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .idleReq   (idleReq),
    .nmi       (nmi),
    .irqReq    (irqReq),
    .intEnable (intEnable),
    .ctrl      (ctrl)
  );

  lp_idle_gates #(.NUM_CSI(NUM_CSI), .NUM_UART(NUM_UART)) u_gates (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .mainClkRun  (mainClkRun),
    .pllOnCfg    (pllOnCfg),
    .mainStopReq (mainStopReq),
    .tmrClkSel   (tmrClkSel),
    .watchClkSub (watchClkSub),
    .wdtClkSel   (wdtClkSel),
    .csiExtClk   (csiExtClk),
    .uart0ExtClk (uart0ExtClk),
    .clkEnCpu    (clkEnCpu),
    .clkEnDma    (clkEnDma),
    .clkEnIntc   (clkEnIntc),
    .clkEnAux    (clkEnAux),
    .clkEnTmr    (clkEnTmr),
    .clkEnWatch  (clkEnWatch),
    .clkEnWdt    (clkEnWdt),
    .clkEnCsi    (clkEnCsi),
    .clkEnUart   (clkEnUart),
    .clkEnKey    (clkEnKey),
    .portHold    (portHold),
    .subOscEn    (subOscEn),
    .ringOscEn   (ringOscEn),
    .pllEn       (pllEn),
    .mainStopAck (mainStopAck),
    .wakeValid   (wakeValid),
    .wakeBranch  (wakeBranch)
  );

  assign idleOn = ctrl.gateOff;

endmodule

// File: rtl/lp_idle_chk.sv
module lp_idle_chk (
  input logic clk,
  input logic rstN,
  input logic idleReq,
  input logic nmi,
  input logic irqReq,
  input logic intEnable,
  input logic mainClkRun,
  input logic pllOnCfg,
  input logic mainStopReq,
  input logic idleOn,
  input logic clkEnCpu,
  input logic clkEnDma,
  input logic clkEnIntc,
  input logic clkEnAux,
  input logic pllEn,
  input logic mainStopAck,
  input logic wakeValid,
  input logic wakeBranch
);

  // R2: entry takes one edge
  a_r2_enter: assert property (@(posedge clk) disable iff (!rstN)
    (!idleOn && idleReq) |=> idleOn);

  // R2: core clocks gated while idle
  a_r2_core_gated: assert property (@(posedge clk) disable iff (!rstN)
    idleOn |-> (!clkEnCpu && !clkEnDma && !clkEnIntc && !clkEnAux));

  // R4: PLL stopped in idle with main clock stopped
  a_r4_pll_off: assert property (@(posedge clk) disable iff (!rstN)
    (idleOn && !mainClkRun) |-> !pllEn);

  // R5: stop request rejected while PLL configured on
  a_r5_stop_reject: assert property (@(posedge clk) disable iff (!rstN)
    (mainStopReq && pllOnCfg) |-> !mainStopAck);

  // R10: non-maskable wake branches
  a_r10_nmi_branch: assert property (@(posedge clk) disable iff (!rstN)
    (idleOn && nmi) |=> (wakeValid && wakeBranch));

  // R11: maskable wake follows the enable
  a_r11_irq_code: assert property (@(posedge clk) disable iff (!rstN)
    (idleOn && !nmi && irqReq) |=> (wakeValid && (wakeBranch == $past(intEnable))));

  // R12: one-cycle restore
  a_r12_restore: assert property (@(posedge clk) disable iff (!rstN)
    (idleOn && (nmi || irqReq)) |=> (!idleOn && clkEnCpu && clkEnDma && clkEnIntc && clkEnAux));

  // R12: wake pulse is a single cycle
  a_r12_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wakeValid |=> !wakeValid);

endmodule

bind lp_idle_ctrl lp_idle_chk u_chk (.*);

// File: tb/lp_idle_ctrl_test.sv
`timescale 1ns/1ps
module lp_idle_ctrl_test;

  localparam int NC = 5;
  localparam int NU = 3;

  logic clk = 1'b0;
  logic rstN;
  logic idleReq, nmi, irqReq, intEnable, mainClkRun, pllOnCfg, mainStopReq;
  logic [1:0] tmrClkSel, wdtClkSel;
  logic watchClkSub, uart0ExtClk;
  logic [NC-1:0] csiExtClk;
  logic idleOn, clkEnCpu, clkEnDma, clkEnIntc, clkEnAux, clkEnTmr, clkEnWatch, clkEnWdt;
  logic [NC-1:0] clkEnCsi;
  logic [NU-1:0] clkEnUart;
  logic clkEnKey, portHold, subOscEn, ringOscEn, pllEn, mainStopAck, wakeValid, wakeBranch;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lp_idle_ctrl #(.NUM_CSI(NC), .NUM_UART(NU)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic defaults();
    idleReq = 0; nmi = 0; irqReq = 0; intEnable = 0; mainClkRun = 1;
    pllOnCfg = 0; mainStopReq = 0; tmrClkSel = 0; watchClkSub = 0;
    wdtClkSel = 0; csiExtClk = '0; uart0ExtClk = 0;
  endtask

  task automatic enterIdle();
    idleReq = 1; @(negedge clk); idleReq = 0;
  endtask

  task automatic t_reset();
    defaults(); rstN = 0;
    repeat (2) @(negedge clk);
    chk("R1 idleOn", idleOn, 0);
    chk("R1 wakeValid", wakeValid, 0);
    chk("R1 wakeBranch", wakeBranch, 0);
    chk("R1 portHold", portHold, 0);
    chk("R1 enables", {clkEnCpu, clkEnDma, clkEnIntc, clkEnAux, clkEnTmr, clkEnWatch, clkEnWdt, clkEnCsi, clkEnUart}, {7'h7f, {NC{1'b1}}, {NU{1'b1}}});
    rstN = 1; @(negedge clk);
  endtask

  task automatic t_entry_and_selects();
    enterIdle();
    chk("R2 idleOn", idleOn, 1);
    chk("R2 core gated", {clkEnCpu, clkEnDma, clkEnIntc, clkEnAux}, 0);
    chk("R3 osc", {subOscEn, ringOscEn}, 2'b11);
    chk("R9 key", clkEnKey, 1);
    chk("R9 portHold", portHold, 1);
    for (int s = 0; s < 4; s++) begin
      tmrClkSel = s[1:0]; wdtClkSel = s[1:0]; #1;
      chk("R6 timer", clkEnTmr, (s == 1 || s == 2));
      chk("R7 watchdog", clkEnWdt, (s == 1 || s == 2));
    end
    watchClkSub = 0; #1; chk("R7 watch off", clkEnWatch, 0);
    watchClkSub = 1; #1; chk("R7 watch sub", clkEnWatch, 1);
    csiExtClk = 5'b10101; uart0ExtClk = 0; #1;
    chk("R8 csi", clkEnCsi, 5'b10101);
    chk("R8 uart none", clkEnUart, 3'b000);
    uart0ExtClk = 1; #1;
    chk("R8 uart0 ext", clkEnUart, 3'b001);
    pllOnCfg = 1; mainClkRun = 1; #1; chk("R4 pll idle main on", pllEn, 1);
    mainClkRun = 0; #1; chk("R4 pll idle main off", pllEn, 0);
    pllOnCfg = 0; mainClkRun = 1;
    nmi = 1; @(negedge clk); nmi = 0;
    @(negedge clk);
    tmrClkSel = 0; wdtClkSel = 0; watchClkSub = 0; csiExtClk = '0; uart0ExtClk = 0; #1;
    chk("R9 key run", clkEnKey, 1);
    chk("R9 portHold run", portHold, 0);
    chk("R6 R7 R8 run enables", {clkEnTmr, clkEnWatch, clkEnWdt, clkEnCsi, clkEnUart}, {3'b111, {NC{1'b1}}, {NU{1'b1}}});
    pllOnCfg = 1; mainClkRun = 0; #1; chk("R4 pll run", pllEn, 1);
    pllOnCfg = 0; mainClkRun = 1;
  endtask

  task automatic t_stop();
    mainStopReq = 1; pllOnCfg = 1; #1; chk("R5 reject", mainStopAck, 0);
    pllOnCfg = 0; #1; chk("R5 grant", mainStopAck, 1);
    mainStopReq = 0; #1; chk("R5 idle no req", mainStopAck, 0);
    @(negedge clk);
  endtask

  task automatic wakeWith(input string req, input logic n, input logic i, input logic ie, input logic expBr);
    enterIdle();
    nmi = n; irqReq = i; intEnable = ie;
    #1; chk({req, " still idle"}, idleOn, 1);
    @(negedge clk);
    nmi = 0; irqReq = 0;
    chk({req, " wakeValid"}, wakeValid, 1);
    chk({req, " wakeBranch"}, wakeBranch, expBr);
    chk("R12 restored", {idleOn, clkEnCpu, clkEnDma, clkEnIntc, clkEnAux}, 5'b01111);
    @(negedge clk);
    chk("R12 pulse ends", wakeValid, 0);
  endtask

  task automatic t_wakes();
    wakeWith("R10 nmi DI", 1, 0, 0, 1);
    wakeWith("R10 nmi EI", 1, 1, 1, 1);
    wakeWith("R11 irq EI", 0, 1, 1, 1);
    wakeWith("R11 irq DI", 0, 1, 0, 0);
    intEnable = 0;
  endtask

  task automatic t_reset_in_idle();
    enterIdle();
    chk("R13 pre idle", idleOn, 1);
    #1 rstN = 0; #1;
    chk("R13 idleOn", idleOn, 0);
    chk("R13 core on", {clkEnCpu, clkEnDma, clkEnIntc, clkEnAux}, 4'hf);
    chk("R13 wake quiet", {wakeValid, wakeBranch}, 0);
    @(negedge clk); rstN = 1; @(negedge clk);
    chk("R13 stays run", idleOn, 0);
  endtask

  initial begin
    t_reset();
    t_entry_and_selects();
    t_stop();
    t_wakes();
    t_reset_in_idle();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule